// File: doc/BRIEF.md
# Salsa20 Core with Diagonal State Layout

This block evaluates the Salsa20 core function on a 512-bit state of sixteen 32-bit words. The caller supplies the state already rearranged so that the four diagonal words share one row. In that arrangement a column round and a row round both act on the four lanes of the same four rows. Going from one kind of round to the other only rotates lanes inside rows and exchanges the roles of two rows. One round, which is four quarterrounds side by side, is computed per clock.

When the last round is done, the working state is added word by word to the saved input. The sum is mapped back to natural word order, registered on the output bus and flagged with a single-cycle done pulse. The result stays on the output bus until the next computation completes. Key expansion, nonce and counter management and keystream XOR are handled by the surrounding logic.

Top module: `salsa_diag_core`

## Requirements
- R1: The input bus is in diagonal order. Slot s = 4*r + c (row r = 0..3, lane c = 0..3) occupies bits [32*s+31:32*s] and carries natural word (4*r + 5*c) mod 16. Rows 0..3 therefore hold words {0,5,10,15}, {4,9,14,3}, {8,13,2,7} and {12,1,6,11}.
- R2: The output bus is in natural order, with word n in bits [32*n+31:32*n].
- R3: The result equals the Salsa20 core of the input: column rounds and row rounds alternate, starting with a column round. Each quarterround performs b ^= (a+d)<<<7, then c ^= (b+a)<<<9, then d ^= (c+b)<<<13, then a ^= (d+c)<<<18. Afterwards every word is added modulo 2^32 to its input word.
- R4: The requested round count is rounded up to an even number, and a request of 0 runs 2 rounds.
- R5: With N effective rounds, done is high for exactly one cycle, after the N-th clock edge that follows the edge on which start was sampled. The new result appears on the output in that same cycle.
- R6: A start pulse that arrives while a computation is in progress is ignored. It changes neither the result nor the timing of done.
- R7: While reset is asserted (synchronous, active low), done is 0 and the output bus is all zeros.
- R8: Between done pulses the output bus holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a computation; sampled only while idle |
| round_req | input | 5 | Requested round count |
| state_in | input | 512 | Input state in diagonal order |
| state_out | output | 512 | Result in natural word order |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Each result is due exactly N clock edges after the edge that samples start, where N is the effective round count after R4 rounding. For every run the bench computes N from the request itself. It then steps edge by edge, sampling 1 ns after each rising edge: done must be low on edges 1 to N-1 and high on edge N. The output is compared with a behavioural Salsa20 model on edge N. One edge later the bench confirms that done has dropped, and some cycles after that it confirms that the output has not moved. In the ignored-start case a second start is driven mid-run, and the same schedule and expected value still apply.

// File: rtl/salsa_diag_pkg.sv
// Shared types and helpers for the diagonal-layout Salsa20 core.
// A row holds four 32-bit lanes, with lane 0 in the low bits.
package salsa_diag_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int ROWS   = 4;
    localparam int WORDS  = ROWS * LANES;
    localparam int ROW_W  = WORD_W * LANES;
    localparam int BUS_W  = WORD_W * WORDS;

    typedef logic [WORD_W-1:0]            word_t;
    typedef logic [LANES-1:0][WORD_W-1:0] row_t;

    // Left rotate of one word by a fixed amount.
    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // Lane rotate of a row: result lane i takes source lane (i+n) mod LANES.
    function automatic row_t lane_rot(input row_t r, input int unsigned n);
        row_t o;
        for (int i = 0; i < LANES; i++) o[i] = r[(i + n) % LANES];
        return o;
    endfunction
endpackage

// File: rtl/salsa_qr.sv
// One quarterround on a single lane, purely combinational.
// Assumes that the caller has already picked the a/b/c/d operands for the current round kind.
module salsa_qr
    import salsa_diag_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    output word_t a_o,
    output word_t b_o,
    output word_t c_o,
    output word_t d_o
);
    word_t b1, c1, d1, a1;

    // Four dependent add-rotate-xor steps, in the fixed order.
    always_comb begin
        b1 = b_i ^ rotl(a_i + d_i, 7);
        c1 = c_i ^ rotl(b1 + a_i, 9);
        d1 = d_i ^ rotl(c1 + b1, 13);
        a1 = a_i ^ rotl(d1 + c1, 18);
    end

    assign a_o = a1;
    assign b_o = b1;
    assign c_o = c1;
    assign d_o = d1;
endmodule

// File: rtl/salsa_round.sv
// One full round on the diagonal-layout state: four quarterrounds run side by side.
// The state is always stored in column layout. For a row round the operands are
// lane-rotated views (b from row 3 rotated by 1, c from row 2 by 2, d from row 1 by 3),
// and the results are rotated back so that the stored layout never changes.
module salsa_round
    import salsa_diag_pkg::*;
(
    input  row_t ra_i,
    input  row_t rb_i,
    input  row_t rc_i,
    input  row_t rd_i,
    input  logic row_phase_i,
    output row_t ra_o,
    output row_t rb_o,
    output row_t rc_o,
    output row_t rd_o
);
    row_t op_a, op_b, op_c, op_d;
    row_t q_a, q_b, q_c, q_d;

    // Operand selection: pass-through for a column round, rotated views for a row round.
    always_comb begin
        op_a = ra_i;
        op_b = row_phase_i ? lane_rot(rd_i, 1) : rb_i;
        op_c = row_phase_i ? lane_rot(rc_i, 2) : rc_i;
        op_d = row_phase_i ? lane_rot(rb_i, 3) : rd_i;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        salsa_qr u_qr (
            .a_i(op_a[l]), .b_i(op_b[l]), .c_i(op_c[l]), .d_i(op_d[l]),
            .a_o(q_a[l]),  .b_o(q_b[l]),  .c_o(q_c[l]),  .d_o(q_d[l])
        );
    end

    // Return the results to column layout, undoing the lane rotations.
    always_comb begin
        ra_o = q_a;
        rb_o = row_phase_i ? lane_rot(q_d, 1) : q_b;
        rc_o = row_phase_i ? lane_rot(q_c, 2) : q_c;
        rd_o = row_phase_i ? lane_rot(q_b, 3) : q_d;
    end
endmodule

// File: rtl/salsa_finish.sv
// Feedforward addition followed by the return to natural order, purely combinational.
// Diagonal slot s = 4*r + c holds natural word (4*r + 5*c) mod 16; the map is fixed wiring.
module salsa_finish
    import salsa_diag_pkg::*;
(
    input  logic [BUS_W-1:0] work_i,
    input  logic [BUS_W-1:0] orig_i,
    output logic [BUS_W-1:0] nat_o
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < LANES; c++) begin : g_col
            localparam int SLOT = r * LANES + c;
            localparam int NAT  = (r * LANES + (LANES + 1) * c) % WORDS;
            assign nat_o[NAT*WORD_W +: WORD_W] =
                work_i[SLOT*WORD_W +: WORD_W] + orig_i[SLOT*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/salsa_diag_core.sv
// Salsa20 core with the state held in diagonal layout.
// Start is sampled only while idle. The input is latched twice, as working state and as
// the feedforward copy. One round is computed per clock, alternating column and row rounds.
// On the final round edge the feedforward sum, in natural order, is registered and done pulses.
// Assumes that state_in is already in diagonal order (see the brief).
module salsa_diag_core
    import salsa_diag_pkg::*;
#(
    parameter int RCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RCNT_W-1:0] round_req,
    input  logic [511:0]      state_in,
    output logic [511:0]      state_out,
    output logic              done
);
    localparam int REM_W = RCNT_W + 1;

    logic [BUS_W-1:0] work_q, orig_q, work_nxt, fin;
    logic [REM_W-1:0] rem_q, eff_rounds;
    logic             busy_q, phase_q;
    row_t             na, nb, nc, nd;

    // Effective round count: round up to even, with a floor of two rounds.
    always_comb begin
        if (round_req == '0) eff_rounds = REM_W'(2);
        else                 eff_rounds = REM_W'(round_req) + REM_W'(round_req[0]);
    end

    salsa_round u_round (
        .ra_i(row_t'(work_q[0*ROW_W +: ROW_W])),
        .rb_i(row_t'(work_q[1*ROW_W +: ROW_W])),
        .rc_i(row_t'(work_q[2*ROW_W +: ROW_W])),
        .rd_i(row_t'(work_q[3*ROW_W +: ROW_W])),
        .row_phase_i(phase_q),
        .ra_o(na), .rb_o(nb), .rc_o(nc), .rd_o(nd)
    );

    assign work_nxt = {nd, nc, nb, na};

    salsa_finish u_finish (
        .work_i(work_nxt),
        .orig_i(orig_q),
        .nat_o (fin)
    );

    // Sequencing: load on start while idle, one round per cycle, register the result at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            phase_q   <= 1'b0;
            rem_q     <= '0;
            work_q    <= '0;
            orig_q    <= '0;
            state_out <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    work_q  <= state_in;
                    orig_q  <= state_in;
                    rem_q   <= eff_rounds;
                    phase_q <= 1'b0;
                    busy_q  <= 1'b1;
                end
            end else begin
                work_q  <= work_nxt;
                phase_q <= ~phase_q;
                rem_q   <= rem_q - REM_W'(1);
                if (rem_q == REM_W'(1)) begin
                    busy_q    <= 1'b0;
                    state_out <= fin;
                    done      <= 1'b1;
                end
            end
        end
    end

    // done never lasts two cycles.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Each completion closes a computation that was active on the previous cycle.
    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy_q) && !busy_q));

    // Outside a completion the output does not move.
    assert_out_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(state_out));

    // A fresh computation starts with an even count of at least two, in the column phase.
    assert_even_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !$past(busy_q)) |-> (!rem_q[0] && rem_q >= REM_W'(2) && !phase_q));

    // While running, the loaded inputs are not overwritten, so a late start has no effect.
    assert_orig_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(orig_q));
endmodule

// File: tb/test_salsa_diag_core.sv
`timescale 1ns/1ps
module test_salsa_diag_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [4:0]   round_req = '0;
    logic [511:0] state_in = '0;
    logic [511:0] state_out;
    logic         done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    salsa_diag_core i_salsa_diag_core (
        .clk(clk), .rst_n(rst_n), .start(start), .round_req(round_req),
        .state_in(state_in), .state_out(state_out), .done(done)
    );

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual=%0d expected<=100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic void qr(inout logic [31:0] s[16], input int a, input int b,
                               input int c, input int d);
        s[b] ^= rl(s[a] + s[d], 7);
        s[c] ^= rl(s[b] + s[a], 9);
        s[d] ^= rl(s[c] + s[b], 13);
        s[a] ^= rl(s[d] + s[c], 18);
    endfunction

    // Behavioural core in natural order (R3), R4 rounding applied here.
    function automatic logic [511:0] ref_core(input logic [31:0] x[16], input int req);
        logic [31:0] s[16];
        logic [511:0] o;
        int n;
        n = (req == 0) ? 2 : req + (req % 2);
        s = x;
        for (int k = 0; k < n; k++) begin
            if (k % 2 == 0) begin
                qr(s, 0, 4, 8, 12); qr(s, 5, 9, 13, 1);
                qr(s, 10, 14, 2, 6); qr(s, 15, 3, 7, 11);
            end else begin
                qr(s, 0, 1, 2, 3); qr(s, 5, 6, 7, 4);
                qr(s, 10, 11, 8, 9); qr(s, 15, 12, 13, 14);
            end
        end
        for (int i = 0; i < 16; i++) o[32*i +: 32] = s[i] + x[i];
        return o;
    endfunction

    // R1 packing: slot 4r+c carries word (4r+5c) mod 16.
    function automatic logic [511:0] to_diag(input logic [31:0] x[16]);
        logic [511:0] b;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                b[32*(4*r+c) +: 32] = x[(4*r + 5*c) % 16];
        return b;
    endfunction

    // Common run: start, step edge by edge, check done timing (R5), result (R2/R3),
    // optional stray start mid-run (R6), and hold afterwards (R8).
    task automatic run_one(input string tag, input logic [31:0] x[16], input int req,
                           input bit inject);
        logic [511:0] exp, held;
        int n;
        n = (req == 0) ? 2 : req + (req % 2);
        exp = ref_core(x, req);
        @(negedge clk);
        state_in = to_diag(x);
        round_req = 5'(req);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            #1;
            chk({tag, " R5 done timing"}, {511'b0, done}, {511'b0, (k == n)});
            if (inject && k == 2 && n > 3) begin
                state_in = ~state_in;
                round_req = 5'd30;
                start = 1'b1;
            end
            if (inject && k == 3) start = 1'b0;
        end
        chk({tag, " R3 R2 result"}, state_out, exp);
        held = state_out;
        start = 1'b0;
        @(posedge clk);
        #1;
        chk({tag, " R5 single pulse"}, {511'b0, done}, 512'b0);
        repeat (4) @(posedge clk);
        #1;
        chk({tag, " R8 output held"}, state_out, held);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R7 reset done", {511'b0, done}, 512'b0);
        chk("R7 reset output", state_out, 512'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_zero8();
        logic [31:0] x[16];
        for (int i = 0; i < 16; i++) x[i] = '0;
        run_one("zero 8 rounds", x, 8, 0);
    endtask

    task automatic t_rand(input int req);
        logic [31:0] x[16];
        for (int i = 0; i < 16; i++) x[i] = $urandom;
        run_one($sformatf("random %0d rounds", req), x, req, 0);
    endtask

    task automatic t_odd();
        logic [31:0] x[16];
        for (int i = 0; i < 16; i++) x[i] = $urandom;
        run_one("R4 odd request 3", x, 3, 0);
    endtask

    task automatic t_zero_req();
        logic [31:0] x[16];
        for (int i = 0; i < 16; i++) x[i] = 32'h0101_0101 * i;
        run_one("R4 zero request", x, 0, 0);
    endtask

    task automatic t_busy_start();
        logic [31:0] x[16];
        for (int i = 0; i < 16; i++) x[i] = $urandom;
        run_one("R6 start while busy", x, 12, 1);
    endtask

    task automatic t_idle_quiet();
        logic [511:0] held;
        held = state_out;
        repeat (6) @(posedge clk);
        #1;
        chk("R8 idle hold", state_out, held);
        chk("R5 idle no done", {511'b0, done}, 512'b0);
    endtask

    initial begin
        void'($urandom(32'h5a17));
        t_reset();
        t_zero8();
        t_rand(8);
        t_rand(12);
        t_rand(20);
        t_odd();
        t_zero_req();
        t_busy_start();
        t_idle_quiet();
        t_rand(20);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule